// File: doc/BRIEF.md
# Rotor stall and clock-loss supervisor

This block sequences protection for a brushless spindle driver. It counts pulses from a slow, externally generated timebase. It holds the power stage off and raises a reset pulse at power-up. It then lets the drive run on request and watches two activity sources against that timebase: the rotor tach signal and the speed reference clock.

If the tach signal stops switching for too long, the block latches a stall fault and shuts the drive off. If the reference clock goes quiet, the block leaves normal control and pulses the drive on and off. If the clock comes back before the stall time runs out, normal drive resumes. If it does not, the stall latch takes over. Thermal and undervoltage flags cut the drive directly, whatever the sequencer state.

The sequencer has five states: `SG_POR` (power-up reset), `SG_IDLE` (stopped), `SG_RUN` (normal drive), `SG_PULSE` (intermittent drive) and `SG_LOCK` (latched stall). The transitions are:

- power-up done: `SG_POR` to `SG_IDLE`
- start: `SG_IDLE` to `SG_RUN`
- clock lost: `SG_RUN` to `SG_PULSE`
- clock back: `SG_PULSE` to `SG_RUN`
- stall: `SG_RUN` or `SG_PULSE` to `SG_LOCK`
- stop: any state except `SG_POR` to `SG_IDLE`

In `SG_RUN` and `SG_PULSE`, stop takes priority over stall, and stall takes priority over a change in clock status.

Top module: `spindle_guard`

## Requirements
- R1: After reset, `por_pulse` is 1 and `drive_en` is 0 until `POR_TICKS` (default 4) timebase ticks have been counted. Two cycles after that tick, `por_pulse` is 0 and the block is stopped.
- R2: While stopped (`stop_req` = 1), `drive_en`, `pulse_mode` and `stall_fault` are all 0. One cycle after `stop_req` is sampled high in any running or faulted state, `drive_en` is 0.
- R3: One clock cycle after `stop_req` goes low in the stopped state, `drive_en` is 1 and `pulse_mode` is 0.
- R4: The stall timer counts ticks since the last rising tach edge (polarity set by `TACH_FALLING`, default 0 = rising). It is cleared on start. When it reaches `STALL_TICKS` (default 31), the block enters the latched stall state, with `stall_fault` = 1 and `drive_en` = 0. At `STALL_TICKS`-1 ticks it is still driving.
- R5: Once latched, the stall state ignores tach and reference activity. It is left only by `stop_req` = 1 or by reset.
- R6: In normal drive, `LOSS_TICKS` (default 2) ticks without a rising reference edge switch the block to intermittent drive (`pulse_mode` = 1). One tick without a reference edge does not.
- R7: On entering intermittent drive, `drive_en` is 0. Each later tick inverts it.
- R8: A rising reference edge during intermittent drive returns the block to normal drive (`pulse_mode` = 0, `drive_en` = 1) within two cycles, provided the stall timer has not expired.
- R9: During intermittent drive, tach edges do not restart the stall timer. Stall time is measured from the last tach edge seen in normal drive.
- R10: While `therm_fault` or `uv_fault` is 1, `drive_en` is 0 in the same cycle. The sequencer state is unchanged, so drive returns as soon as both flags are clear.
- R11: Starting with no reference clock and a spinning rotor first gives intermittent drive after `LOSS_TICKS` ticks. It then gives the latched stall state `STALL_TICKS` ticks after the last tach edge seen in normal drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tb_tick | input | 1 | One-cycle pulse per slow timebase period |
| tach | input | 1 | Rotor tach level, synchronous to clk |
| ref_clk | input | 1 | Speed reference clock level, synchronous to clk |
| stop_req | input | 1 | 1 = stop request, 0 = run request |
| therm_fault | input | 1 | Over-temperature flag |
| uv_fault | input | 1 | Supply undervoltage flag |
| drive_en | output | 1 | Power-stage enable |
| pulse_mode | output | 1 | Intermittent-drive flag |
| stall_fault | output | 1 | Latched stall flag |
| por_pulse | output | 1 | Power-up reset pulse |

## Verification
Timer results (power-up end, stall, clock loss) are due two cycles after the deciding tick: one cycle for the counter and one for the state register. Reference restoration takes the same two cycles after the edge. Start and stop show one cycle after the request, and the fault gating of `drive_en` shows in the same cycle.

Every tick task in the bench ends with two idle cycles, and the bench samples on the falling clock edge, so each check reads settled values. The sweeps walk the tick count across each threshold (stall 29 to 32, clock loss 1 to 4) and compute the expected state and drive phase from that count.

// File: rtl/spindle_guard_pkg.sv
package spindle_guard_pkg;

    typedef enum logic [2:0] {
        SG_POR   = 3'd0,
        SG_IDLE  = 3'd1,
        SG_RUN   = 3'd2,
        SG_PULSE = 3'd3,
        SG_LOCK  = 3'd4
    } sg_state_e;

endpackage

// File: rtl/sg_edge.sv
module sg_edge #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic edge_o
);

    logic prev_q;

    // Reset to the level that cannot produce a spurious edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= ~FALLING;
        else        prev_q <= sig;
    end

    generate
        if (FALLING) begin : g_fall
            assign edge_o = prev_q & ~sig;
        end else begin : g_rise
            assign edge_o = sig & ~prev_q;
        end
    endgenerate

endmodule

// File: rtl/sg_tick_timer.sv
module sg_tick_timer #(
    parameter int LIMIT = 31
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic rearm,
    input  logic tick,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Saturating count of ticks since the last clear or rearm.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (clear || rearm)    cnt_q <= '0;
        else if (tick && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q == LIM);

endmodule

// File: rtl/spindle_guard.sv
module spindle_guard
    import spindle_guard_pkg::*;
#(
    parameter int POR_TICKS    = 4,
    parameter int STALL_TICKS  = 31,
    parameter int LOSS_TICKS   = 2,
    parameter bit TACH_FALLING = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tb_tick,
    input  logic tach,
    input  logic ref_clk,
    input  logic stop_req,
    input  logic therm_fault,
    input  logic uv_fault,
    output logic drive_en,
    output logic pulse_mode,
    output logic stall_fault,
    output logic por_pulse
);

    sg_state_e state_q, state_d;
    logic      tach_edge, ref_edge;
    logic      por_done, stall_exp, ref_lost;
    logic      phase_q;
    logic      parked;
    logic      hw_block;

    assign parked   = (state_q == SG_POR) || (state_q == SG_IDLE);
    assign hw_block = therm_fault | uv_fault;

    sg_edge #(.FALLING(TACH_FALLING)) u_tach_edge (
        .clk(clk), .rst_n(rst_n), .sig(tach), .edge_o(tach_edge)
    );

    sg_edge #(.FALLING(1'b0)) u_ref_edge (
        .clk(clk), .rst_n(rst_n), .sig(ref_clk), .edge_o(ref_edge)
    );

    // Power-up pulse length.
    sg_tick_timer #(.LIMIT(POR_TICKS)) u_por_timer (
        .clk(clk), .rst_n(rst_n), .clear(1'b0), .rearm(1'b0),
        .tick(tb_tick), .expired(por_done)
    );

    // Stall timer: tach edges rearm it only in normal drive.
    sg_tick_timer #(.LIMIT(STALL_TICKS)) u_stall_timer (
        .clk(clk), .rst_n(rst_n), .clear(parked),
        .rearm(tach_edge && (state_q == SG_RUN)),
        .tick(tb_tick), .expired(stall_exp)
    );

    // Reference-loss timer.
    sg_tick_timer #(.LIMIT(LOSS_TICKS)) u_ref_timer (
        .clk(clk), .rst_n(rst_n), .clear(parked), .rearm(ref_edge),
        .tick(tb_tick), .expired(ref_lost)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SG_POR;
        else        state_q <= state_d;
    end

    // Intermittent-drive phase.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   phase_q <= 1'b0;
        else if (state_q != SG_PULSE) phase_q <= 1'b0;
        else if (tb_tick)             phase_q <= ~phase_q;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SG_POR: begin
                if (por_done) state_d = SG_IDLE;
            end
            SG_IDLE: begin
                if (!stop_req) state_d = SG_RUN;
            end
            SG_RUN: begin
                if (stop_req)       state_d = SG_IDLE;
                else if (stall_exp) state_d = SG_LOCK;
                else if (ref_lost)  state_d = SG_PULSE;
            end
            SG_PULSE: begin
                if (stop_req)       state_d = SG_IDLE;
                else if (stall_exp) state_d = SG_LOCK;
                else if (!ref_lost) state_d = SG_RUN;
            end
            SG_LOCK: begin
                if (stop_req) state_d = SG_IDLE;
            end
            default: state_d = SG_POR;
        endcase
    end

    // Output logic.
    always_comb begin
        drive_en    = 1'b0;
        pulse_mode  = 1'b0;
        stall_fault = 1'b0;
        por_pulse   = 1'b0;
        unique case (state_q)
            SG_POR:   por_pulse = 1'b1;
            SG_IDLE:  ;
            SG_RUN:   drive_en = ~hw_block;
            SG_PULSE: begin
                pulse_mode = 1'b1;
                drive_en   = phase_q & ~hw_block;
            end
            SG_LOCK:  stall_fault = 1'b1;
            default:  por_pulse = 1'b1;
        endcase
    end

endmodule

// File: rtl/spindle_guard_chk.sv
module spindle_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic stop_req,
    input logic therm_fault,
    input logic uv_fault,
    input logic drive_en,
    input logic pulse_mode,
    input logic stall_fault,
    input logic por_pulse
);

    assert_fault_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_fault || uv_fault) |-> !drive_en);

    assert_por_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        por_pulse |-> (!drive_en && !stall_fault && !pulse_mode));

    assert_stop_cuts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !drive_en);

    assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_fault && !stop_req) |=> stall_fault);

    assert_lock_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall_fault |-> (!pulse_mode && !drive_en));

    assert_pulse_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_mode) |-> !drive_en);

endmodule

bind spindle_guard spindle_guard_chk u_chk (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
    .therm_fault(therm_fault), .uv_fault(uv_fault),
    .drive_en(drive_en), .pulse_mode(pulse_mode),
    .stall_fault(stall_fault), .por_pulse(por_pulse)
);

// File: tb/spindle_guard_bench.sv
module spindle_guard_bench;

    localparam int CLK_PERIOD = 10;
    localparam int POR_T   = 4;
    localparam int STALL_T = 31;
    localparam int LOSS_T  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tb_tick = 1'b0, tach = 1'b0, ref_clk = 1'b0;
    logic stop_req = 1'b1, therm_fault = 1'b0, uv_fault = 1'b0;
    logic drive_en, pulse_mode, stall_fault, por_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spindle_guard u_spindle_guard (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .tach(tach),
        .ref_clk(ref_clk), .stop_req(stop_req), .therm_fault(therm_fault),
        .uv_fault(uv_fault), .drive_en(drive_en), .pulse_mode(pulse_mode),
        .stall_fault(stall_fault), .por_pulse(por_pulse)
    );

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {drive,pulse,stall,por} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {drive_en, pulse_mode, stall_fault, por_pulse};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Optional tach/ref edges, then one tick, then two settle cycles.
    task automatic tick_cycle(input bit with_tach, input bit with_ref);
        @(negedge clk); tach = with_tach; ref_clk = with_ref;
        @(negedge clk); tach = 1'b0;      ref_clk = 1'b0;
        @(negedge clk); tb_tick = 1'b1;
        @(negedge clk); tb_tick = 1'b0;
        cyc(2);
    endtask

    task automatic ref_pulse();
        @(negedge clk); ref_clk = 1'b1;
        @(negedge clk); ref_clk = 1'b0;
        cyc(2);
    endtask

    task automatic restart();
        @(negedge clk); stop_req = 1'b1;
        cyc(2);
        check(outs(), 4'b0000, "R2 stopped");
        stop_req = 1'b0;
        cyc(1);
        check(outs(), 4'b1000, "R3 start");
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        check(outs(), 4'b0001, "R1 por after reset");
        for (int i = 1; i <= POR_T; i++) begin
            tick_cycle(1'b0, 1'b0);
            check(outs(), (i < POR_T) ? 4'b0001 : 4'b0000, "R1 por length");
        end

        // Stall threshold sweep (R4), reference present every tick.
        for (int k = STALL_T - 2; k <= STALL_T + 1; k++) begin
            restart();
            for (int i = 0; i < k; i++) tick_cycle(1'b0, 1'b1);
            check(outs(), (k >= STALL_T) ? 4'b0010 : 4'b1000, "R4 stall threshold");
        end
        // Locked: activity ignored (R5), stop clears.
        for (int i = 0; i < 3; i++) tick_cycle(1'b1, 1'b1);
        ref_pulse();
        check(outs(), 4'b0010, "R5 lock holds");

        // Clock-loss sweep (R6, R7), then restore (R8).
        for (int j = 1; j <= 4; j++) begin
            logic [3:0] e;
            restart();
            for (int i = 0; i < j; i++) tick_cycle(1'b1, 1'b0);
            if (j < LOSS_T) e = 4'b1000;
            else            e = {((j - LOSS_T) % 2 == 1), 3'b100};
            check(outs(), e, (j < LOSS_T) ? "R6 no loss" : "R7 pulse phase");
            ref_pulse();
            check(outs(), 4'b1000, "R8 restore");
        end

        // Start with no reference (R11, R9).
        restart();
        for (int n = 1; n <= STALL_T + 1; n++) begin
            tick_cycle(1'b1, 1'b0);
            if (n == LOSS_T)
                check({pulse_mode, stall_fault}, 4'b0010, "R11 enters pulse");
            if (n == STALL_T)
                check({pulse_mode, stall_fault}, 4'b0010, "R9 tach ignored, not yet stalled");
        end
        check(outs(), 4'b0010, "R11 lock after pulse");
        ref_pulse();
        check(outs(), 4'b0010, "R5 late reference no restart");

        // Fault gating sweep (R10).
        restart();
        for (int m = 0; m < 4; m++) begin
            @(negedge clk); therm_fault = m[0]; uv_fault = m[1];
            #1;
            check(outs(), (m == 0) ? 4'b1000 : 4'b0000, "R10 fault gate");
        end
        @(negedge clk); therm_fault = 1'b0; uv_fault = 1'b0;
        cyc(1);
        check(outs(), 4'b1000, "R10 drive returns");
        @(negedge clk); stop_req = 1'b1;
        cyc(1);
        check(outs(), 4'b0000, "R2 stop");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule